// File: doc/BRIEF.md
# Trigger Link Frame Mapper

On every bunch crossing the block takes two 36-bit trigger primitive words, called word A and word B, and builds three 32-bit frames for serial trigger links. Each frame has 24 payload bits. Every payload bit is picked from one of the 64 data bits of the two words, as set by a bit-mapping table. The frame also carries the crossing markers taken from word A and four odd-parity bits. Each parity bit guards one 7-bit slice of the frame.

The table holds up to 256 mappings. A register chooses which one is active. Software loads the table one entry at a time, and each entry sets the source bit for one payload position. Serialization, optics, occupancy histograms and the move into the link clock domain belong to other blocks.

Top module: `tlm_frame_mapper`

## Requirements
- R1: A synchronous reset (`rst` high) sets every frame to 32'hF000_0000, which means payload and marker bits are zero and the four parity bits are one. Reset also clears `bc0_err` and sets the active mapping to 0. Reset leaves the table contents unchanged.
- R2: Words sampled at clock edge k appear in `link_frames` after edge k+1. The fixed latency is two register stages.
- R3: Link l (0..2) occupies `link_frames[32l+31:32l]`. Its bit b (0..23) equals source bit s, where s is the active mapping's entry for position p = 24l + b. If s < 32, the source bit is word A bit s. Otherwise it is word B bit s-32.
- R4: In every link, bit 24 is word A bit 35 (the crossing-zero marker), and bits 25, 26 and 27 are word A bits 32, 33 and 34 (the bunch counter).
- R5: For k = 0..3, bit 28+k is set so that frame bits 7k..7k+6 together with bit 28+k hold an odd number of ones.
- R6: When `tbl_we` is high on an edge, entry (`tbl_map`, `tbl_pos`) is set to `tbl_src`. The new entry applies to words sampled on later edges. Words sampled on the same edge still use the old entry.
- R7: When `sel_we` is high on an edge, `sel_map` becomes the active mapping for words sampled on later edges.
- R8: A table write with `tbl_pos` of 72 or more changes no entry.
- R9: `bc0_err` goes high with the same timing as the frame of any crossing whose two bit-35 values differ. It stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crossing clock |
| rst | input | 1 | Synchronous reset, active high |
| word_a | input | 36 | First primitive word: data 31:0, bunch counter 34:32, crossing-zero 35 |
| word_b | input | 36 | Second primitive word, same layout |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_map | input | 8 | Mapping number being written |
| tbl_pos | input | 7 | Payload position being written (0..71) |
| tbl_src | input | 6 | Source bit index (0..63) |
| sel_we | input | 1 | Active-mapping load strobe |
| sel_map | input | 8 | New active mapping number |
| link_frames | output | 96 | Three 32-bit frames, link 0 in the low bits |
| bc0_err | output | 1 | Sticky crossing-zero mismatch flag |

## Verification
A walking single one across all 64 source bits checks that each payload position takes exactly the bit its entry names. A swapped word, an offset index or a wrong link slice shows up as a lone bit in the wrong place. Random words with varied bunch counters exercise the marker field and the parity bits over many bit counts. Switching the active mapping and rewriting entries of the active mapping and another mapping, in the same cycle as new data, test the boundary of when a change takes effect. Out-of-range writes are followed by traffic on the affected mapping. A single mismatched crossing, followed by clean ones and then a reset, tests that the error flag is sticky and that it clears.

// File: rtl/tlm_pkg.sv
package tlm_pkg;
   localparam int IN_W    = 36;
   localparam int DATA_W  = 32;
   localparam int SRC_W   = 2 * DATA_W;
   localparam int IDX_W   = $clog2(SRC_W);
   localparam int BCN_LSB = 32;
   localparam int BCN_W   = 3;
   localparam int BC0_POS = 35;
   localparam int MARK_W  = 1 + BCN_W;
   localparam int GRP_W   = 7;

   // parity bit that makes the group plus itself carry an odd count of ones
   function automatic logic odd_fill(input logic [GRP_W-1:0] grp);
      return ~(^grp);
   endfunction
endpackage

// File: rtl/tlm_map_store.sv
module tlm_map_store import tlm_pkg::*; #(
   parameter int MAP_COUNT = 256,
   parameter int POS_TOT   = 72,
   parameter int MAP_W     = 8,
   parameter int POS_W     = 7,
   localparam int ROW_W    = POS_TOT * IDX_W
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             tbl_we,
   input  logic [MAP_W-1:0] tbl_map,
   input  logic [POS_W-1:0] tbl_pos,
   input  logic [IDX_W-1:0] tbl_src,
   input  logic             sel_we,
   input  logic [MAP_W-1:0] sel_map,
   output logic [ROW_W-1:0] row_q
);
   logic [ROW_W-1:0] mem [MAP_COUNT];
   logic [MAP_W-1:0] sel_q;

   // entry storage is not reset; positions past the last payload bit are dropped
   always_ff @(posedge clk) begin
      if (tbl_we && (tbl_pos < POS_W'(POS_TOT)))
         mem[tbl_map][int'(tbl_pos)*IDX_W +: IDX_W] <= tbl_src;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sel_q <= '0;
         row_q <= '0;
      end else begin
         if (sel_we) sel_q <= sel_map;
         row_q <= mem[sel_q];
      end
   end
endmodule

// File: rtl/tlm_bit_pick.sv
module tlm_bit_pick import tlm_pkg::*; #(
   parameter int POS_TOT = 72
)(
   input  logic [SRC_W-1:0]         src_bits,
   input  logic [POS_TOT*IDX_W-1:0] row,
   output logic [POS_TOT-1:0]       picked
);
   for (genvar p = 0; p < POS_TOT; p++) begin : g_pos
      assign picked[p] = src_bits[row[p*IDX_W +: IDX_W]];
   end
endmodule

// File: rtl/tlm_frame_pack.sv
module tlm_frame_pack import tlm_pkg::*; #(
   parameter int PAY_W     = 24,
   localparam int BODY_W   = PAY_W + MARK_W,
   localparam int N_GRP    = BODY_W / GRP_W,
   localparam int FRAME_W  = BODY_W + N_GRP
)(
   input  logic [PAY_W-1:0]   payload,
   input  logic               bc0,
   input  logic [BCN_W-1:0]   bcn,
   output logic [FRAME_W-1:0] frame
);
   logic [BODY_W-1:0] body;
   logic [N_GRP-1:0]  par;

   assign body = {bcn, bc0, payload};

   for (genvar g = 0; g < N_GRP; g++) begin : g_par
      assign par[g] = odd_fill(body[g*GRP_W +: GRP_W]);
   end

   assign frame = {par, body};
endmodule

// File: rtl/tlm_frame_mapper.sv
module tlm_frame_mapper import tlm_pkg::*; #(
   parameter int N_LINKS   = 3,
   parameter int PAY_W     = 24,
   parameter int MAP_COUNT = 256,
   localparam int MAP_W    = (MAP_COUNT > 1) ? $clog2(MAP_COUNT) : 1,
   localparam int POS_TOT  = N_LINKS * PAY_W,
   localparam int POS_W    = $clog2(POS_TOT),
   localparam int BODY_W   = PAY_W + MARK_W,
   localparam int N_GRP    = BODY_W / GRP_W,
   localparam int FRAME_W  = BODY_W + N_GRP
)(
   input  logic                       clk,
   input  logic                       rst,
   input  logic [IN_W-1:0]            word_a,
   input  logic [IN_W-1:0]            word_b,
   input  logic                       tbl_we,
   input  logic [MAP_W-1:0]           tbl_map,
   input  logic [POS_W-1:0]           tbl_pos,
   input  logic [IDX_W-1:0]           tbl_src,
   input  logic                       sel_we,
   input  logic [MAP_W-1:0]           sel_map,
   output logic [N_LINKS*FRAME_W-1:0] link_frames,
   output logic                       bc0_err
);
   localparam logic [FRAME_W-1:0] IDLE_FRAME = {{N_GRP{1'b1}}, {BODY_W{1'b0}}};

   // elaboration-time parameter checks
   if ((BODY_W % GRP_W) != 0) begin : g_bad_body
      $error("payload plus markers must split into whole parity groups");
   end
   if (N_LINKS < 1 || PAY_W < 1) begin : g_bad_links
      $error("need at least one link with a payload");
   end
   if (MAP_COUNT < 1 || MAP_COUNT > (1 << MAP_W)) begin : g_bad_maps
      $error("mapping count out of range");
   end
   if (SRC_W != (1 << IDX_W)) begin : g_bad_src
      $error("source index must address the data bits exactly");
   end

   logic [IN_W-1:0]              a_q;
   logic [DATA_W-1:0]            b_data_q;
   logic                         b_bc0_q;
   logic [POS_TOT*IDX_W-1:0]     row;
   logic [POS_TOT-1:0]           picked;
   logic [N_LINKS*FRAME_W-1:0]   frame_d;
   logic                         unused_b_bcn;

   assign unused_b_bcn = ^word_b[BCN_LSB +: BCN_W];

   // stage 1: capture words
   always_ff @(posedge clk) begin
      if (rst) begin
         a_q      <= '0;
         b_data_q <= '0;
         b_bc0_q  <= 1'b0;
      end else begin
         a_q      <= word_a;
         b_data_q <= word_b[DATA_W-1:0];
         b_bc0_q  <= word_b[BC0_POS];
      end
   end

   tlm_map_store #(
      .MAP_COUNT(MAP_COUNT), .POS_TOT(POS_TOT), .MAP_W(MAP_W), .POS_W(POS_W)
   ) u_store (
      .clk(clk), .rst(rst),
      .tbl_we(tbl_we), .tbl_map(tbl_map), .tbl_pos(tbl_pos), .tbl_src(tbl_src),
      .sel_we(sel_we), .sel_map(sel_map),
      .row_q(row)
   );

   tlm_bit_pick #(.POS_TOT(POS_TOT)) u_pick (
      .src_bits({b_data_q, a_q[DATA_W-1:0]}),
      .row(row),
      .picked(picked)
   );

   for (genvar l = 0; l < N_LINKS; l++) begin : g_link
      tlm_frame_pack #(.PAY_W(PAY_W)) u_pack (
         .payload(picked[l*PAY_W +: PAY_W]),
         .bc0(a_q[BC0_POS]),
         .bcn(a_q[BCN_LSB +: BCN_W]),
         .frame(frame_d[l*FRAME_W +: FRAME_W])
      );
   end

   // stage 2: frames and sticky marker check
   always_ff @(posedge clk) begin
      if (rst) begin
         link_frames <= {N_LINKS{IDLE_FRAME}};
         bc0_err     <= 1'b0;
      end else begin
         link_frames <= frame_d;
         if (a_q[BC0_POS] != b_bc0_q) bc0_err <= 1'b1;
      end
   end
endmodule

// File: rtl/tlm_frame_mapper_chk.sv
module tlm_frame_mapper_chk import tlm_pkg::*; #(
   parameter int N_LINKS  = 3,
   parameter int PAY_W    = 24,
   localparam int BODY_W  = PAY_W + MARK_W,
   localparam int N_GRP   = BODY_W / GRP_W,
   localparam int FRAME_W = BODY_W + N_GRP
)(
   input logic                       clk,
   input logic                       rst,
   input logic [MARK_W-1:0]          a_mark,
   input logic                       b_bc0,
   input logic [N_LINKS*FRAME_W-1:0] link_frames,
   input logic                       bc0_err
);
   localparam logic [FRAME_W-1:0] IDLE_FRAME = {{N_GRP{1'b1}}, {BODY_W{1'b0}}};

   logic [1:0] warm;
   always_ff @(posedge clk) begin
      if (rst) warm <= '0;
      else if (warm != 2'd3) warm <= warm + 2'd1;
   end

   // R1
   a_r1_reset_idle: assert property (@(posedge clk)
      rst |=> (link_frames == {N_LINKS{IDLE_FRAME}}) && !bc0_err);

   // R9
   a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
      bc0_err |=> bc0_err);
   a_r9_err_set: assert property (@(posedge clk) disable iff (rst)
      (warm >= 2'd2) && $past(a_mark[MARK_W-1] ^ b_bc0, 2) |-> bc0_err);

   for (genvar l = 0; l < N_LINKS; l++) begin : g_l
      // R4, R2
      a_r4_marker_field: assert property (@(posedge clk) disable iff (rst)
         (warm >= 2'd2) |->
         link_frames[l*FRAME_W + PAY_W +: MARK_W]
            == {$past(a_mark[MARK_W-2:0], 2), $past(a_mark[MARK_W-1], 2)});
      if (l > 0) begin : g_same
         a_r4_links_agree: assert property (@(posedge clk) disable iff (rst)
            link_frames[l*FRAME_W + PAY_W +: MARK_W] == link_frames[PAY_W +: MARK_W]);
      end
      for (genvar g = 0; g < N_GRP; g++) begin : g_g
         // R5
         a_r5_odd_group: assert property (@(posedge clk) disable iff (rst)
            (^{link_frames[l*FRAME_W + g*GRP_W +: GRP_W],
               link_frames[l*FRAME_W + BODY_W + g]}) == 1'b1);
      end
   end
endmodule

bind tlm_frame_mapper tlm_frame_mapper_chk #(.N_LINKS(N_LINKS), .PAY_W(PAY_W)) u_chk (
   .clk(clk),
   .rst(rst),
   .a_mark(word_a[35:32]),
   .b_bc0(word_b[35]),
   .link_frames(link_frames),
   .bc0_err(bc0_err)
);

// File: tb/tlm_frame_mapper_tb.sv
module tlm_frame_mapper_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [35:0] word_a = '0;
   logic [35:0] word_b = '0;
   logic        tbl_we = 1'b0;
   logic [7:0]  tbl_map = '0;
   logic [6:0]  tbl_pos = '0;
   logic [5:0]  tbl_src = '0;
   logic        sel_we = 1'b0;
   logic [7:0]  sel_map = '0;
   logic [95:0] link_frames;
   logic        bc0_err;

   always #(CLK_PERIOD/2) clk = ~clk;

   tlm_frame_mapper u_dut (
      .clk(clk), .rst(rst), .word_a(word_a), .word_b(word_b),
      .tbl_we(tbl_we), .tbl_map(tbl_map), .tbl_pos(tbl_pos), .tbl_src(tbl_src),
      .sel_we(sel_we), .sel_map(sel_map),
      .link_frames(link_frames), .bc0_err(bc0_err)
   );

   int    n_chk = 0;
   int    n_bad = 0;
   bit    chk_on = 1'b0;
   bit    done = 1'b0;
   string phase = "R1";

   // reference model state
   int          mtab [int];
   int          m_sel = 0;
   bit          m_acc = 1'b0;
   logic [95:0] exp1, exp2;
   bit          err1, err2;

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   function automatic logic [95:0] model_frames(logic [35:0] a, logic [35:0] b, int map);
      logic [95:0] f = '0;
      for (int p = 0; p < 72; p++) begin
         int key = map * 128 + p;
         int s = mtab.exists(key) ? mtab[key] : 0;
         f[(p / 24) * 32 + (p % 24)] = (s < 32) ? a[s] : b[s - 32];
      end
      for (int l = 0; l < 3; l++) begin
         f[l*32 + 24] = a[35];
         f[l*32 + 25] = a[32];
         f[l*32 + 26] = a[33];
         f[l*32 + 27] = a[34];
         for (int k = 0; k < 4; k++) begin
            int ones = $countones(f[l*32 + 7*k +: 7]);
            f[l*32 + 28 + k] = (ones % 2 == 0);
         end
      end
      return f;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         exp1 = {3{32'hF000_0000}};
         exp2 = exp1;
         err1 = 1'b0; err2 = 1'b0; m_acc = 1'b0;
         m_sel = 0;
      end else begin
         exp2 = exp1;
         err2 = err1;
         exp1 = model_frames(word_a, word_b, m_sel);
         m_acc = m_acc | (word_a[35] ^ word_b[35]);
         err1 = m_acc;
         if (sel_we) m_sel = int'(sel_map);
      end
      if (tbl_we && tbl_pos < 7'd72) mtab[int'(tbl_map) * 128 + int'(tbl_pos)] = int'(tbl_src);
   end

   always @(negedge clk) begin
      if (chk_on && !rst) begin
         for (int l = 0; l < 3; l++) begin
            logic [31:0] g = link_frames[l*32 +: 32];
            logic [31:0] e = exp2[l*32 +: 32];
            check($sformatf("R3 %s link%0d payload", phase, l), g & 32'h00FF_FFFF, e & 32'h00FF_FFFF);
            check($sformatf("R4 %s link%0d markers", phase, l), g & 32'h0F00_0000, e & 32'h0F00_0000);
            check($sformatf("R5 %s link%0d parity", phase, l), g & 32'hF000_0000, e & 32'hF000_0000);
         end
         check($sformatf("R9 %s err flag", phase), {31'b0, bc0_err}, {31'b0, err2});
      end
   end

   task automatic tick();
      @(negedge clk);
      tbl_we = 1'b0;
      sel_we = 1'b0;
   endtask

   task automatic rand_words(bit mismatch);
      bit z = 1'($urandom);
      word_a = {z, 3'($urandom), 32'($urandom)};
      word_b = {z ^ mismatch, 3'($urandom), 32'($urandom)};
   endtask

   task automatic reset_checks();
      for (int l = 0; l < 3; l++)
         check($sformatf("R1 reset link%0d", l), link_frames[l*32 +: 32], 32'hF000_0000);
      check("R1 reset err", {31'b0, bc0_err}, 32'd0);
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired in phase %s", phase);
         summary();
         $finish;
      end
   end

   initial begin
      int maps [4] = '{0, 1, 7, 255};
      @(negedge clk);
      repeat (3) tick();
      reset_checks();
      rst = 1'b0;
      tick();
      // program four mappings
      foreach (maps[i]) begin
         for (int p = 0; p < 72; p++) begin
            int s;
            case (i)
               0: s = p % 64;
               1: s = 63 - (p % 64);
               2: s = (p * 5 + 3) % 64;
               default: s = 32 + (p % 32);
            endcase
            tbl_we = 1'b1; tbl_map = 8'(maps[i]); tbl_pos = 7'(p); tbl_src = 6'(s);
            tick();
         end
      end
      chk_on = 1'b1;
      // R2 R3: walking one, then random words, on mapping 0
      phase = "R2 walk";
      for (int i = 0; i < 64; i++) begin
         logic [63:0] d = 64'd1 << i;
         word_a = {4'b0, d[31:0]};
         word_b = {4'b0, d[63:32]};
         tick();
      end
      phase = "R2 random";
      repeat (40) begin rand_words(1'b0); tick(); end
      // R7: switch mappings with data in the same cycle
      phase = "R7 select";
      foreach (maps[i]) begin
         sel_we = 1'b1; sel_map = 8'(maps[3 - i]);
         rand_words(1'b0); tick();
         repeat (15) begin rand_words(1'b0); tick(); end
      end
      sel_we = 1'b1; sel_map = 8'd7; rand_words(1'b0); tick();
      // R6: rewrite active and inactive entries alongside traffic
      phase = "R6 rewrite";
      for (int i = 0; i < 40; i++) begin
         tbl_we = 1'b1; tbl_map = (i % 2 == 0) ? 8'd7 : 8'd1;
         tbl_pos = 7'($urandom_range(71)); tbl_src = 6'($urandom);
         rand_words(1'b0); tick();
      end
      repeat (5) begin rand_words(1'b0); tick(); end
      // R8: positions beyond the payload are ignored
      phase = "R8 out of range";
      for (int p = 72; p < 128; p++) begin
         tbl_we = 1'b1; tbl_map = 8'd7; tbl_pos = 7'(p); tbl_src = 6'($urandom);
         rand_words(1'b0); tick();
      end
      repeat (20) begin rand_words(1'b0); tick(); end
      // R9: one mismatched crossing sets a sticky flag
      phase = "R9 mismatch";
      repeat (5) begin rand_words(1'b0); tick(); end
      rand_words(1'b1); tick();
      repeat (10) begin rand_words(1'b0); tick(); end
      // R1: second reset clears flag and selection, table kept
      chk_on = 1'b0;
      rst = 1'b1;
      rand_words(1'b0);
      repeat (3) tick();
      phase = "R1 after reset";
      reset_checks();
      rst = 1'b0;
      chk_on = 1'b1;
      repeat (25) begin rand_words(1'b0); tick(); end
      done = 1'b1;
      summary();
      $finish;
   end
endmodule